// File: doc/BRIEF.md
# Set-Associative Page Translator with Fault Reporting

This block translates 32-bit virtual addresses with 8 KiB pages through a table of four ways, each holding sixteen two-word entries. A request uses the low four bits of the page number to select one slot in every way. It then compares each slot's page tag and process tag against the request. On a hit the block returns the physical frame address and the granted permissions. A failed lookup returns an exception vector, and the block records the refill slot and the fault cause in two state registers that the refill handler reads.

A parameter selects an instruction translator (vector base 4) or a data translator (vector base 8). For a miss, a 16-bit parity-feedback LFSR picks the refill way. The LFSR steps only on faults. Debug lookups return a result but leave the LFSR and both registers unchanged. Entries are loaded through a single-cycle write port that takes a way, an index and both entry words.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, rsp_vld_o, sel_o and cause_o are zero and the LFSR holds 0xCCCC, so the first non-debug miss names way 0.
- R2: A way hits when its page tag (high word bits 31:13) equals vaddr_i bits 31:13, and either its global flag (low word bit 4) is set or its process tag (high word bits 7:0) equals pid_i. When several ways hit, the lowest-numbered way is used. fault_o is 0 only for a hit that passes every enabled check.
- R3: On a hit, phys_o is the hit entry's frame number (low word bits 31:13) shifted left by 13. With no hit, phys_o is 0.
- R4: Checks are applied in a fixed priority, and the first one that fails sets vec_o. First: kernel check (chk_i[2]) with the entry's kernel-only flag (bit 2) set and user_i high gives base+2. Second: a write (acc_i=1) with write check (chk_i[3]) and the writable flag (bit 1) clear gives base+3. Third: an execute (acc_i=2) with exec check (chk_i[1]) and the executable flag (bit 0) clear gives base+3. Fourth: valid check (chk_i[0]) with the valid flag (bit 3) clear gives base+1. A miss gives base+0. Base is 4 for the instruction variant and 8 for the data variant.
- R5: On success, perm_o[0] (read) is 1, perm_o[1] (write) equals the writable flag, and perm_o[2] (execute) is 1 only in the instruction variant and only when chk_i[1] or the executable flag is set. On a fault, perm_o is 0.
- R6: A non-debug fault loads sel_o with the index in bits 3:0 and a way in bits 5:4. The way is the hit way for a protection fault, or LFSR bits 1:0 taken before the step for a miss.
- R7: Each non-debug fault steps the LFSR: it shifts right by one, and bit 15 receives the parity of (state AND 0x8805). Hits do not step it.
- R8: A non-debug fault loads cause_o with pid_i in bits 7:0, the access code in bits 9:8 (read 0, write 1, execute 2) and the page number in bits 31:13. Bits 12:10 keep their value.
- R9: A lookup with dbg_i high changes none of the LFSR, sel_o and cause_o.
- R10: rsp_vld_o and the result outputs are updated on the clock edge that samples req_i.
- R11: An entry written with wr_en_i is used by lookups from the next cycle onward, and a rewrite replaces the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_set_i | input | 2 | Way to write |
| wr_idx_i | input | 4 | Index to write |
| wr_hi_i | input | 32 | Tag word (page tag, process tag) |
| wr_lo_i | input | 32 | Frame word (frame, flags) |
| req_i | input | 1 | Lookup request |
| vaddr_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access code: 0 read, 1 write, 2 execute |
| user_i | input | 1 | Request is from user mode |
| dbg_i | input | 1 | Debug lookup, no state update |
| pid_i | input | 8 | Current process tag |
| chk_i | input | 4 | Check enables: 0 valid, 1 exec, 2 kernel, 3 write |
| rsp_vld_o | output | 1 | Result valid |
| fault_o | output | 1 | Lookup failed |
| vec_o | output | 4 | Exception vector |
| phys_o | output | 32 | Physical address of the frame |
| perm_o | output | 3 | Granted {execute, write, read} |
| sel_o | output | 6 | Refill slot: way in 5:4, index in 3:0 |
| cause_o | output | 32 | Fault cause register |

## Verification
Every way and index is filled with entries whose flag patterns cycle through all combinations. Way 3 is global. One index holds a duplicate tag in ways 1 and 2, which shows whether the lowest-numbered way wins. Each entry is looked up with the three access codes, both privilege levels, several check-enable masks, and both a matching and a foreign process tag. This separates the priority of the four checks and the tag-match rule. Misses and debug misses are interleaved with hits, so the refill way reported in the selection register follows the LFSR sequence, and it is visible whether hits or debug lookups disturb that sequence. A data and an instruction instance receive the same stimulus, which separates the vector bases and the execute grant.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PG_SHIFT = 13;
  localparam int unsigned VPN_W    = 32 - PG_SHIFT;
  localparam int unsigned PID_W    = 8;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  // low word flag positions
  localparam int unsigned F_X = 0;
  localparam int unsigned F_W = 1;
  localparam int unsigned F_K = 2;
  localparam int unsigned F_V = 3;
  localparam int unsigned F_G = 4;

  // check enable positions in chk_i
  localparam int unsigned C_V = 0;
  localparam int unsigned C_X = 1;
  localparam int unsigned C_K = 2;
  localparam int unsigned C_W = 3;

  typedef enum logic [1:0] {
    OFF_MISS = 2'd0,
    OFF_INV  = 2'd1,
    OFF_PRIV = 2'd2,
    OFF_PERM = 2'd3
  } vec_off_e;
endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [31:0]      whi_i,
  input  logic [31:0]      wlo_i,
  input  logic [IDX_W-1:0] ridx_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PID_W-1:0] pid_i,
  output logic             hit_o,
  output logic [31:0]      lo_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [31:0] hi_q [DEPTH];
  logic [31:0] lo_q [DEPTH];
  logic [31:0] hi_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        hi_q[i] <= '0;
        lo_q[i] <= '0;
      end
    end else if (we_i) begin
      hi_q[widx_i] <= whi_i;
      lo_q[widx_i] <= wlo_i;
    end
  end

  assign hi_r  = hi_q[ridx_i];
  assign lo_o  = lo_q[ridx_i];
  assign hit_o = (lo_o[F_G] || hi_r[PID_W-1:0] == pid_i) && hi_r[31:PG_SHIFT] == vpn_i;
endmodule

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter logic [15:0] SEED = 16'hCCCC,
  parameter logic [15:0] TAPS = 16'h8805
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  output logic [15:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= SEED;
    else if (step_i) state_o <= {^(state_o & TAPS), state_o[15:1]};
  end
endmodule

// File: rtl/tlb_check.sv
module tlb_check
  import tlb_pkg::*;
#(
  parameter bit IS_INSN = 1'b0
) (
  input  logic [31:0] lo_i,
  input  logic [1:0]  acc_i,
  input  logic        user_i,
  input  logic [3:0]  chk_i,
  output logic        flt_o,
  output vec_off_e    off_o,
  output logic [2:0]  perm_o
);
  always_comb begin
    flt_o = 1'b1;
    off_o = OFF_MISS;
    if (chk_i[C_K] && lo_i[F_K] && user_i)                 off_o = OFF_PRIV;
    else if (acc_i == ACC_WR && chk_i[C_W] && !lo_i[F_W])  off_o = OFF_PERM;
    else if (acc_i == ACC_EX && chk_i[C_X] && !lo_i[F_X])  off_o = OFF_PERM;
    else if (chk_i[C_V] && !lo_i[F_V])                     off_o = OFF_INV;
    else                                                   flt_o = 1'b0;
    perm_o = '0;
    if (!flt_o) begin
      perm_o[0] = 1'b1;
      perm_o[1] = lo_i[F_W];
      perm_o[2] = IS_INSN && (chk_i[C_X] || lo_i[F_X]);
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter bit          IS_INSN   = 1'b0,
  parameter int unsigned SETS      = 4,
  parameter int unsigned IDX_W     = 4,
  parameter logic [15:0] LFSR_SEED = 16'hCCCC,
  parameter logic [15:0] LFSR_TAPS = 16'h8805
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_set_i,
  input  logic [3:0]  wr_idx_i,
  input  logic [31:0] wr_hi_i,
  input  logic [31:0] wr_lo_i,
  input  logic        req_i,
  input  logic [31:0] vaddr_i,
  input  logic [1:0]  acc_i,
  input  logic        user_i,
  input  logic        dbg_i,
  input  logic [7:0]  pid_i,
  input  logic [3:0]  chk_i,
  output logic        rsp_vld_o,
  output logic        fault_o,
  output logic [3:0]  vec_o,
  output logic [31:0] phys_o,
  output logic [2:0]  perm_o,
  output logic [5:0]  sel_o,
  output logic [31:0] cause_o
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam logic [3:0]  VBASE = IS_INSN ? 4'd4 : 4'd8;

  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx;
  logic [SETS-1:0]  hit_v;
  logic [31:0]      lo_v [SETS];
  logic             any_hit;
  logic [SET_W-1:0] hit_set;
  logic [31:0]      hit_lo;
  logic             prot_flt, flt;
  vec_off_e         off;
  logic [2:0]       perm;
  logic [15:0]      lfsr;
  logic             upd;
  logic [SET_W-1:0] rf_set;

  assign vpn = vaddr_i[31:PG_SHIFT];
  assign idx = vpn[IDX_W-1:0];

  for (genvar s = 0; s < SETS; s++) begin : g_way
    tlb_way #(.IDX_W(IDX_W)) u_way (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en_i && wr_set_i == SET_W'(s)),
      .widx_i (wr_idx_i[IDX_W-1:0]),
      .whi_i  (wr_hi_i),
      .wlo_i  (wr_lo_i),
      .ridx_i (idx),
      .vpn_i  (vpn),
      .pid_i  (pid_i),
      .hit_o  (hit_v[s]),
      .lo_o   (lo_v[s])
    );
  end

  // lowest-numbered hitting way wins
  always_comb begin
    hit_set = '0;
    for (int s = SETS - 1; s >= 0; s--)
      if (hit_v[s]) hit_set = SET_W'(s);
  end
  assign any_hit = |hit_v;
  assign hit_lo  = lo_v[hit_set];

  tlb_check #(.IS_INSN(IS_INSN)) u_check (
    .lo_i   (hit_lo),
    .acc_i  (acc_i),
    .user_i (user_i),
    .chk_i  (chk_i),
    .flt_o  (prot_flt),
    .off_o  (off),
    .perm_o (perm)
  );

  assign flt    = !any_hit || prot_flt;
  assign upd    = req_i && flt && !dbg_i;
  assign rf_set = any_hit ? hit_set : lfsr[SET_W-1:0];

  tlb_lfsr #(.SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (upd),
    .state_o (lfsr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_vld_o <= 1'b0;
      fault_o   <= 1'b0;
      vec_o     <= '0;
      phys_o    <= '0;
      perm_o    <= '0;
    end else begin
      rsp_vld_o <= req_i;
      if (req_i) begin
        fault_o <= flt;
        vec_o   <= VBASE + (any_hit ? 4'(off) : 4'd0);
        phys_o  <= any_hit ? {hit_lo[31:PG_SHIFT], {PG_SHIFT{1'b0}}} : '0;
        perm_o  <= any_hit ? perm : 3'b000;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= '0;
      cause_o <= '0;
    end else if (upd) begin
      sel_o                  <= 6'({rf_set, idx});
      cause_o[PID_W-1:0]     <= pid_i;
      cause_o[9:8]           <= acc_i;
      cause_o[31:PG_SHIFT]   <= vpn;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter bit IS_INSN = 1'b0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        dbg_i,
  input logic        rsp_vld_o,
  input logic        fault_o,
  input logic [3:0]  vec_o,
  input logic [2:0]  perm_o,
  input logic [5:0]  sel_o,
  input logic [31:0] cause_o
);
  localparam logic [1:0] BASE_HI = IS_INSN ? 2'd1 : 2'd2;

  p_rsp_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_vld_o);
  p_ok_reads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && !fault_o) |-> perm_o[0]);
  p_fault_noperm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && fault_o) |-> perm_o == 3'b000);
  p_no_exec_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && !IS_INSN) |-> !perm_o[2]);
  p_vec_base_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o |-> vec_o[3:2] == BASE_HI);
  p_sel_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !dbg_i) |=> $stable(sel_o));
  p_cause_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !dbg_i) |=> $stable(cause_o));
endmodule

bind tlb_xlate tlb_xlate_chk #(.IS_INSN(IS_INSN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .dbg_i     (dbg_i),
  .rsp_vld_o (rsp_vld_o),
  .fault_o   (fault_o),
  .vec_o     (vec_o),
  .perm_o    (perm_o),
  .sel_o     (sel_o),
  .cause_o   (cause_o)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 0, rst_ni = 0;
  logic wr_en_i = 0;
  logic [1:0] wr_set_i = 0;
  logic [3:0] wr_idx_i = 0;
  logic [31:0] wr_hi_i = 0, wr_lo_i = 0;
  logic req_i = 0, user_i = 0, dbg_i = 0;
  logic [31:0] vaddr_i = 0;
  logic [1:0] acc_i = 0;
  logic [7:0] pid_i = 0;
  logic [3:0] chk_i = 0;

  logic rv_d, f_d, rv_i, f_i;
  logic [3:0] v_d, v_i;
  logic [31:0] ph_d, ph_i, c_d, c_i;
  logic [2:0] pm_d, pm_i;
  logic [5:0] s_d, s_i;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tlb_xlate #(.IS_INSN(1'b0)) uut (
    .clk_i, .rst_ni, .wr_en_i, .wr_set_i, .wr_idx_i, .wr_hi_i, .wr_lo_i,
    .req_i, .vaddr_i, .acc_i, .user_i, .dbg_i, .pid_i, .chk_i,
    .rsp_vld_o(rv_d), .fault_o(f_d), .vec_o(v_d), .phys_o(ph_d),
    .perm_o(pm_d), .sel_o(s_d), .cause_o(c_d));

  tlb_xlate #(.IS_INSN(1'b1)) uut_insn (
    .clk_i, .rst_ni, .wr_en_i, .wr_set_i, .wr_idx_i, .wr_hi_i, .wr_lo_i,
    .req_i, .vaddr_i, .acc_i, .user_i, .dbg_i, .pid_i, .chk_i,
    .rsp_vld_o(rv_i), .fault_o(f_i), .vec_o(v_i), .phys_o(ph_i),
    .perm_o(pm_i), .sel_o(s_i), .cause_o(c_i));

  logic [31:0] m_hi [4][16];
  logic [31:0] m_lo [4][16];
  logic [15:0] m_lfsr;
  logic [5:0]  m_sel;
  logic [31:0] m_cause;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic predict(input bit insn, input logic [31:0] va, input logic [1:0] acc,
                         input logic u, input logic [7:0] pid, input logic [3:0] chk,
                         output logic f, output logic [3:0] v, output logic [31:0] ph,
                         output logic [2:0] pm, output logic hit, output logic [1:0] hs);
    logic [31:0] lo;
    int ix;
    ix = int'(va[16:13]);
    hit = 0; hs = 0; lo = 0;
    for (int s = 3; s >= 0; s--)
      if ((m_lo[s][ix][4] || m_hi[s][ix][7:0] == pid) && m_hi[s][ix][31:13] == va[31:13]) begin
        hit = 1; hs = 2'(s); lo = m_lo[s][ix];
      end
    v = insn ? 4'd4 : 4'd8;
    f = 1; pm = 0; ph = hit ? {lo[31:13], 13'd0} : 32'd0;
    if (hit) begin
      if (chk[2] && lo[2] && u) v = v + 2;
      else if (acc == 1 && chk[3] && !lo[1]) v = v + 3;
      else if (acc == 2 && chk[1] && !lo[0]) v = v + 3;
      else if (chk[0] && !lo[3]) v = v + 1;
      else begin
        f = 0;
        pm = {insn && (chk[1] || lo[0]), lo[1], 1'b1};
      end
    end
  endtask

  task automatic wr(input int s, input int i, input logic [31:0] hi, input logic [31:0] lo);
    wr_en_i = 1; wr_set_i = 2'(s); wr_idx_i = 4'(i); wr_hi_i = hi; wr_lo_i = lo;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 0;
    m_hi[s][i] = hi; m_lo[s][i] = lo;
  endtask

  // called at a negedge; returns at the following negedge
  task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic u,
                      input logic d, input logic [7:0] pid, input logic [3:0] chk, input string tag);
    logic fd, fi, hd, hi_; logic [3:0] vd, vi; logic [31:0] pd, pi;
    logic [2:0] md, mi; logic [1:0] sd, si;
    req_i = 1; vaddr_i = va; acc_i = acc; user_i = u; dbg_i = d; pid_i = pid; chk_i = chk;
    predict(0, va, acc, u, pid, chk, fd, vd, pd, md, hd, sd);
    predict(1, va, acc, u, pid, chk, fi, vi, pi, mi, hi_, si);
    if (fd && !d) begin
      m_sel = {hd ? sd : m_lfsr[1:0], va[16:13]};
      m_cause = {va[31:13], m_cause[12:10], acc, pid};
      m_lfsr = {^(m_lfsr & 16'h8805), m_lfsr[15:1]};
    end
    @(posedge clk_i); @(negedge clk_i);
    check({"R10 vld ", tag}, 32'(rv_d), 1);
    check({"R2 fault ", tag}, 32'(f_d), 32'(fd));
    check({"R2 fault insn ", tag}, 32'(f_i), 32'(fi));
    if (fd) check({"R4 vec ", tag}, 32'(v_d), 32'(vd));
    if (fi) check({"R4 vec insn ", tag}, 32'(v_i), 32'(vi));
    check({"R3 phys ", tag}, ph_d, pd);
    check({"R5 perm ", tag}, 32'(pm_d), 32'(md));
    check({"R5 perm insn ", tag}, 32'(pm_i), 32'(mi));
    check({"R6 R7 R9 sel ", tag}, 32'(s_d), 32'(m_sel));
    check({"R8 R9 cause ", tag}, c_d, m_cause);
    check({"R6 sel insn ", tag}, 32'(s_i), 32'(m_sel));
    req_i = 0; dbg_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) for (int i = 0; i < 16; i++) begin
      m_hi[s][i] = 0; m_lo[s][i] = 0;
    end
    m_lfsr = 16'hCCCC; m_sel = 0; m_cause = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 vld", 32'(rv_d), 0);
    check("R1 sel", 32'(s_d), 0);
    check("R1 cause", c_d, 0);
    // R1 R7: first miss names way 0, next way from LFSR step
    look(32'hFFFF_E000, 0, 0, 0, 8'h01, 4'h0, "R1 first miss");
    check("R1 way0", 32'(s_d[5:4]), 0);
    look(32'hFFFF_C000, 1, 1, 0, 8'h02, 4'hF, "R7 second miss");
    check("R7 way after step", 32'(s_d[5:4]), 2);

    // fill table: way 3 global, flags cycle per index
    for (int s = 0; s < 4; s++) for (int i = 0; i < 16; i++)
      wr(s, i, {13'(s + 1), 2'b0, 4'(i), 5'd0, 8'h10 + 8'(s)},
               {19'h40000 | 19'(s << 4) | 19'(i), 8'd0, (s == 3), 4'(i ^ s)});
    // duplicate tag in way 2 at index 5 (same page as way 1): lowest wins (R2)
    wr(2, 5, {13'd2, 2'b0, 4'd5, 5'd0, 8'h11}, 32'hAAAA_A00F);
    // R11: rewrite way 0 index 7 then use it
    wr(0, 7, {13'd1, 2'b0, 4'd7, 5'd0, 8'h10}, 32'h1234_6000 | 32'h0F);
    look({13'd1, 2'b0, 4'd7, 13'd0}, 0, 0, 0, 8'h10, 4'hF, "R11 rewrite");
    check("R11 phys", ph_d, 32'h1234_6000);

    foreach (m_hi[s]) for (int i = 0; i < 16; i++)
      for (int a = 0; a < 3; a++) for (int u = 0; u < 2; u++)
        for (int c = 0; c < 3; c++) begin
          logic [3:0] ck;
          ck = (c == 0) ? 4'h0 : (c == 1) ? 4'hF : 4'(4'h5 << (i % 2));
          look({13'(s + 1), 2'b0, 4'(i), 13'h0ABC}, 2'(a), 1'(u), 0,
               (c == 2) ? 8'h77 : 8'h10 + 8'(s), ck, "R4 sweep");
        end

    // R9: debug misses and debug protection faults change nothing
    for (int k = 0; k < 8; k++) begin
      logic [5:0] sb; logic [31:0] cb;
      sb = s_d; cb = c_d;
      look({13'h1F00 + 13'(k), 2'b0, 4'(k), 13'd0}, 1, 1, 1, 8'h3, 4'hF, "R9 debug");
      check("R9 sel held", 32'(s_d), 32'(sb));
      check("R9 cause held", c_d, cb);
      look({13'h1F00 + 13'(k), 2'b0, 4'(k), 13'd0}, 2'(k % 3), 0, 0, 8'h3, 4'h0, "R7 miss chain");
    end
    // R2: foreign pid to non-global way misses
    look({13'd1, 2'b0, 4'd3, 13'd0}, 0, 0, 0, 8'h99, 4'h0, "R2 pid miss");
    check("R2 pid miss fault", 32'(f_d), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule